// File: doc/BRIEF.md
# Multi-Channel Interval Timer with Shared Prescaler

This block is a bus slave holding a configurable number of down-counting timer channels (one to eight) behind a shared 16-bit reloadable prescaler. The prescaler counts down once per clock. When it reaches zero it reloads and sends a single-cycle tick to every channel. An enabled channel decrements its 32-bit counter on each tick. When a tick arrives while the counter is zero, the channel underflows. On underflow it either reloads from its own reload register (periodic mode) or stops (one-shot mode). If its interrupt is enabled, it raises a one-cycle pulse on its own interrupt line and latches a pending flag.

Software reaches all state through a word-wide register bus: an 8-bit byte address, a write strobe, write data and combinational read data. The unit registers sit in the first 16-byte window: prescaler counter at 0x00, prescaler reload at 0x04 and a read-only capability word at 0x08. Channel n owns the 16-byte window starting at 0x10 + 0x10*n. Inside that window the counter is at +0x0, the reload at +0x4 and the control register at +0x8.

Top module: `tmr_unit`

## Requirements
- R1: After reset the prescaler counter and reload read zero, every channel register reads zero and every interrupt line is low.
- R2: Offset 0x08 reads a fixed capability word: bits 2:0 hold the channel count (modulo 8), bits 7:3 hold the base interrupt number, and bits 8 and 9 read one. With the default parameters of 2 channels and base 8, the word is 0x342. Writes to this offset change nothing.
- R3: Writes to the prescaler counter (0x00) and the prescaler reload (0x04) keep only bits 15:0 of the data. Reads of these registers return the value zero-extended to 32 bits.
- R4: The prescaler counter decrements on every clock. In the clock after it reads zero it takes the reload value and issues a tick, so ticks repeat every reload+1 clocks.
- R5: A read returns zero if address bits 1:0 are non-zero, if it hits offset 0x0C, if it hits offset +0xC of a channel window, or if it hits a window beyond the configured channel count. Writes to any of these addresses change nothing.
- R6: Control bit 0 enables a channel. An enabled channel decrements its counter on each tick and underflows on the tick that finds the counter at zero. A periodic channel with reload L and prescaler reload P therefore underflows every (L+1)*(P+1) clocks.
- R7: If control bit 1 (restart) is set, an underflow copies the reload register into the counter. If it is clear, an underflow clears the enable bit and the counter stays at zero.
- R8: Writing control with bit 2 (load) set copies the channel reload register into the counter. Bit 2 always reads zero.
- R9: If control bit 3 (interrupt enable) is set, an underflow drives the channel's interrupt line high for exactly one clock and sets control bit 4 (pending). If bit 3 is clear, the line stays low and pending is not set.
- R10: Writing control with bit 4 set clears the pending flag. Writing it with bit 4 clear leaves the flag unchanged. An underflow in the same clock as a clearing write leaves the flag set.
- R11: A write to the channel counter offset sets the counter to the written value. A disabled channel holds its counter and reload unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | CHANNELS | One-clock underflow pulse per channel |

## Verification
A prescaler counter holding a wrong value shows as a wrong interval between interrupt pulses of every running channel, starting from the next period. A direct read of offset 0x00 exposes it in the same clock. A channel counter or enable bit that goes wrong shows as a missing, early or late pulse on that channel's interrupt line within one timer period, and as a wrong counter or control value on the next read. A pending flag that is dropped or set without cause shows only on a control read, so the checks read control back after each underflow and after each clearing write.

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CHANNELS = 2,
  parameter int IRQ_BASE = 8,
  parameter int PRE_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [CHANNELS-1:0] irq
);

  localparam logic [31:0] CFG_WORD = 32'h300
                                   | ((32'(IRQ_BASE) & 32'h1F) << 3)
                                   | (32'(CHANNELS) & 32'h7);

  logic [PRE_W-1:0] pre_cnt, pre_rl;
  logic [31:0]      ch_cnt [CHANNELS];
  logic [31:0]      ch_rl  [CHANNELS];
  logic [CHANNELS-1:0] ch_en, ch_rs, ch_ie, ch_pd;

  wire       word_ok = (bus_addr[1:0] == 2'b00);
  wire [3:0] blk     = bus_addr[7:4];
  wire [1:0] reg_sel = bus_addr[3:2];
  wire       unit_sel   = word_ok && (blk == 4'd0);
  wire       pre_cnt_wr = bus_we && unit_sel && (reg_sel == 2'd0);
  wire       pre_rl_wr  = bus_we && unit_sel && (reg_sel == 2'd1);
  wire       tick       = (pre_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      pre_rl  <= '0;
    end else begin
      if (pre_rl_wr) pre_rl <= bus_wdata[PRE_W-1:0];
      if (pre_cnt_wr)  pre_cnt <= bus_wdata[PRE_W-1:0];
      else if (tick)   pre_cnt <= pre_rl;
      else             pre_cnt <= pre_cnt - 1'b1;
    end
  end

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    logic [31:0] cnt, rl;
    logic        en, rs, ie, pd, iq;

    wire sel    = word_ok && (blk == 4'(g + 1));
    wire cnt_wr = bus_we && sel && (reg_sel == 2'd0);
    wire rl_wr  = bus_we && sel && (reg_sel == 2'd1);
    wire ctl_wr = bus_we && sel && (reg_sel == 2'd2);
    wire fire   = en && tick && (cnt == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        rl  <= '0;
        en  <= 1'b0;
        rs  <= 1'b0;
        ie  <= 1'b0;
        pd  <= 1'b0;
        iq  <= 1'b0;
      end else begin
        iq <= fire && ie;
        pd <= (fire && ie) || (pd && !(ctl_wr && bus_wdata[4]));
        if (rl_wr) rl <= bus_wdata;
        if (ctl_wr) begin
          en <= bus_wdata[0];
          rs <= bus_wdata[1];
          ie <= bus_wdata[3];
        end else if (fire && !rs) begin
          en <= 1'b0;
        end
        if (cnt_wr)                      cnt <= bus_wdata;
        else if (ctl_wr && bus_wdata[2]) cnt <= rl;
        else if (fire)                   cnt <= rs ? rl : cnt;
        else if (en && tick)             cnt <= cnt - 1'b1;
      end
    end

    assign ch_cnt[g] = cnt;
    assign ch_rl[g]  = rl;
    assign ch_en[g]  = en;
    assign ch_rs[g]  = rs;
    assign ch_ie[g]  = ie;
    assign ch_pd[g]  = pd;
    assign irq[g]    = iq;
  end

  always_comb begin
    bus_rdata = '0;
    if (word_ok) begin
      if (blk == 4'd0) begin
        case (reg_sel)
          2'd0:    bus_rdata = 32'(pre_cnt);
          2'd1:    bus_rdata = 32'(pre_rl);
          2'd2:    bus_rdata = CFG_WORD;
          default: bus_rdata = '0;
        endcase
      end else begin
        for (int i = 0; i < CHANNELS; i++) begin
          if (blk == 4'(i + 1)) begin
            case (reg_sel)
              2'd0:    bus_rdata = ch_cnt[i];
              2'd1:    bus_rdata = ch_rl[i];
              2'd2:    bus_rdata = {27'd0, ch_pd[i], ch_ie[i], 1'b0, ch_rs[i], ch_en[i]};
              default: bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int CHANNELS = 2,
  parameter int IRQ_BASE = 8,
  parameter int PRE_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [7:0]          bus_addr,
  input logic [31:0]         bus_rdata,
  input logic [CHANNELS-1:0] irq,
  input logic [PRE_W-1:0]    pre_cnt,
  input logic [PRE_W-1:0]    pre_rl,
  input logic                tick,
  input logic                pre_cnt_wr,
  input logic [CHANNELS-1:0] ch_en,
  input logic [CHANNELS-1:0] ch_pd
);

  localparam logic [31:0] CAP = {22'd0, 2'b11, 5'(IRQ_BASE), 3'(CHANNELS)};

  // R4
  pre_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pre_cnt_wr) |=> (pre_cnt == $past(pre_rl)));

  // R4
  pre_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !pre_cnt_wr) |=> (pre_cnt == PRE_W'($past(pre_cnt) - 1'b1)));

  // R2
  cap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h08) |-> (bus_rdata == CAP));

  // R5
  misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (bus_rdata == 32'd0));

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
    // R9
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> ch_pd[g]);

    // R9
    irq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> ($past(tick) && $past(ch_en[g])));
  end

endmodule

bind tmr_unit tmr_unit_chk #(.CHANNELS(CHANNELS), .IRQ_BASE(IRQ_BASE), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .pre_cnt(pre_cnt), .pre_rl(pre_rl), .tick(tick), .pre_cnt_wr(pre_cnt_wr),
  .ch_en(ch_en), .ch_pd(ch_pd)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_unit #(.CHANNELS(2), .IRQ_BASE(8), .PRE_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    #0.5 d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[ch] && n < lim);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); check("R1 prescaler counter", v, 0);
    rd(8'h04, v); check("R1 prescaler reload", v, 0);
    rd(8'h10, v); check("R1 ch0 counter", v, 0);
    rd(8'h28, v); check("R1 ch1 control", v, 0);
    check("R1 irq low", 32'(irq), 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    rd(8'h08, v); check("R2 capability word", v, 32'h342);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R2 write ignored", v, 32'h342);
  endtask

  task automatic t_prescaler;
    logic [31:0] v;
    wr(8'h04, 32'hABCD_0003);
    rd(8'h04, v); check("R3 reload low 16 bits", v, 32'h3);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h5A5A_0003; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    for (int k = 0; k < 5; k++) begin
      rd(8'h00, v);
      check("R4 prescaler count sequence", v, (k == 4) ? 32'h3 : 32'(3 - k));
      @(negedge clk);
    end
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    int n;
    wr(8'h14, 32'd4);
    wr(8'h18, 32'h0F);
    wait_irq(0, 100, n);
    check("R9 first pulse seen", 32'(irq[0]), 1);
    @(negedge clk);
    check("R9 pulse one clock wide", 32'(irq[0]), 0);
    wait_irq(0, 100, n);
    check("R6 period reload 4 prescale 0", 32'(n + 1), 32'd5);
    rd(8'h18, v); check("R8 load reads zero, pending set", v, 32'h1B);
    wr(8'h04, 32'd2);
    wait_irq(0, 200, n);
    wait_irq(0, 200, n);
    wait_irq(0, 200, n);
    check("R6 period reload 4 prescale 2", 32'(n), 32'd15);
    wr(8'h04, 32'd0);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    wr(8'h18, 32'h0B);
    rd(8'h18, v); check("R10 write 0 keeps pending", v & 32'h10, 32'h10);
    wr(8'h18, 32'h10);
    rd(8'h18, v); check("R10 write 1 clears pending", v, 32'h0);
    repeat (10) @(negedge clk);
    check("R11 disabled ch0 holds irq low", 32'(irq[0]), 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    int n, cnt_hi;
    wr(8'h20, 32'd3);
    wr(8'h28, 32'h09);
    wait_irq(1, 100, n);
    check("R9 one-shot pulse", 32'(irq[1]), 1);
    check("R6 underflow after counter+1 ticks", 32'(n), 32'd4);
    cnt_hi = 0;
    repeat (20) begin
      @(negedge clk);
      if (irq[1]) cnt_hi++;
    end
    check("R7 no second pulse in one-shot", 32'(cnt_hi), 0);
    rd(8'h28, v); check("R7 enable cleared after one-shot", v, 32'h18);
    rd(8'h20, v); check("R7 counter stays zero", v, 0);
  endtask

  task automatic t_noirq;
    logic [31:0] v;
    int cnt_hi;
    wr(8'h24, 32'd2);
    wr(8'h28, 32'h17);
    cnt_hi = 0;
    repeat (30) begin
      @(negedge clk);
      if (irq[1]) cnt_hi++;
    end
    check("R9 no pulse when interrupt disabled", 32'(cnt_hi), 0);
    rd(8'h28, v); check("R9 pending not set when disabled", v, 32'h03);
  endtask

  task automatic t_counter_write;
    logic [31:0] v;
    wr(8'h28, 32'h0);
    wr(8'h20, 32'h55AA_1234);
    repeat (5) @(negedge clk);
    rd(8'h20, v); check("R11 counter write held while disabled", v, 32'h55AA_1234);
    wr(8'h24, 32'hDEAD_0001);
    rd(8'h24, v); check("R11 reload readback", v, 32'hDEAD_0001);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(8'h0C, v); check("R5 unit offset 0x0C", v, 0);
    rd(8'h1C, v); check("R5 channel offset +0xC", v, 0);
    wr(8'h34, 32'h1234_5678);
    rd(8'h34, v); check("R5 absent channel reads zero", v, 0);
    rd(8'h19, v); check("R5 misaligned read", v, 0);
    wr(8'h15, 32'h777);
    rd(8'h14, v); check("R5 misaligned write ignored", v, 32'd4);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_prescaler();
    t_periodic();
    t_pending();
    t_oneshot();
    t_noirq();
    t_counter_write();
    t_unmapped();
    done = 1'b1;
    finish_run();
  end
endmodule